// File: doc/BRIEF.md
# Configurable Pad Register Cell

This cell sits between a group of pads and the core logic. It holds three storage banks: a capture bank for data coming in from the pad, a drive bank for data going out, and an enable bank that decides whether the pad is driven. The three banks share one clock and one set/reset line. Each bank has its own clock enable. Elaboration-time parameters choose, for each bank separately, whether it is an edge-triggered flop or a level-sensitive latch. They also choose which of four set/reset behaviours the shared line has on that bank.

The clock, the set/reset line, the three enables, the incoming pad data, the outgoing pad data and the drive enable each have their own inversion parameter. An integrator can therefore adapt the cell to active-low controls, a falling-edge clock or inverted pad data without adding logic around it. The core sees the incoming data twice: once as a registered copy and once straight through. A high-impedance pad is modelled as a separate drive-enable output. Outgoing data is forced low whenever that enable is off.

Top module: `iocell_top`

## Requirements
- R1: While `rst_n` is low, all three banks hold zero. `in_q` is then 0, `pad_oe` is all INV_OE, and `pad_out` follows from R9. Release of `rst_n` is synchronised to the active clock edge.
- R2: A bank in flop mode loads its data at the active clock edge when its enable is active. A data change later in the same clock phase does not reach it.
- R3: A bank in latch mode follows its data while the effective clock is high and its enable is active. It holds the last value while the effective clock is low.
- R4: With its enable inactive and set/reset inactive, a bank keeps its value in both modes, whatever its data input does.
- R5: In the two asynchronous modes, an active set/reset forces the bank at once, without waiting for a clock edge and regardless of the enable.
- R6: In the two synchronous modes, set/reset acts only at an active clock edge (or, in latch mode, during the transparent phase). It takes precedence over an inactive enable.
- R7: Mode codes are 0 synchronous set, 1 synchronous clear, 2 asynchronous preset, 3 asynchronous clear. Storage codes are 0 flop and 1 latch. Set and preset load all ones, and the two clear modes load all zeros. After set/reset is released, the forced value stays until the bank next loads.
- R8: `in_direct` equals `pad_in` XOR INV_IN at every moment. The capture bank stores that same inverted value.
- R9: `pad_oe` is the enable bank XOR INV_OE. `pad_out` is the drive bank XOR INV_OUT on bits where `pad_oe` is 1, and 0 on every other bit.
- R10: Setting the inversion parameter of the clock makes the falling pad-side edge active. Setting the inversion of set/reset or of an enable makes a low level active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, before polarity selection |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sr | input | 1 | Shared set/reset line, before polarity selection |
| in_ce | input | 1 | Enable of the capture bank |
| out_ce | input | 1 | Enable of the drive bank |
| oe_ce | input | 1 | Enable of the drive-enable bank |
| pad_in | input | W | Data arriving from the pads |
| core_out | input | W | Data from the core for the pads |
| core_oe | input | W | Per-bit drive request from the core |
| in_q | output | W | Registered incoming data |
| in_direct | output | W | Unregistered incoming data after polarity |
| pad_out | output | W | Data toward the pads, low when not driven |
| pad_oe | output | W | Per-bit drive enable toward the pads |

## Verification
A bank that holds the wrong value shows it at the ports within one clock phase. The capture bank is visible directly on `in_q`. The drive bank shows on `pad_out` only while its bit is enabled, so each bench check on the drive bank also keeps the enable bank at a known value. The enable bank shows on both `pad_oe` and the masking of `pad_out`. If the set/reset style is wrong, the error is visible in the low phase before the next edge, because an asynchronous bank has already changed and a synchronous one has not. If the storage style is wrong, the error is visible when data changes in the middle of the high phase.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

  typedef enum logic [1:0] {
    SR_SYNC_SET  = 2'd0,
    SR_SYNC_CLR  = 2'd1,
    SR_ASYNC_SET = 2'd2,
    SR_ASYNC_CLR = 2'd3
  } sr_mode_e;

  typedef enum logic {
    ST_FLOP  = 1'b0,
    ST_LATCH = 1'b1
  } st_mode_e;

endpackage

// File: rtl/iocell_rst_sync.sv
module iocell_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/iocell_store.sv
module iocell_store
  import iocell_pkg::*;
#(
  parameter int       W       = 4,
  parameter sr_mode_e SR_MODE = SR_SYNC_CLR,
  parameter st_mode_e ST_MODE = ST_FLOP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sr,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam bit IS_ASYNC = (SR_MODE == SR_ASYNC_SET) || (SR_MODE == SR_ASYNC_CLR);
  localparam bit IS_SET   = (SR_MODE == SR_SYNC_SET)  || (SR_MODE == SR_ASYNC_SET);
  localparam logic [W-1:0] FORCE_VAL = IS_SET ? {W{1'b1}} : {W{1'b0}};

  logic         sync_hit;
  logic         load;
  logic [W-1:0] din;
  logic [W-1:0] q_r;

  // next-state selection: synchronous set/reset outranks the enable
  always_comb begin
    sync_hit = !IS_ASYNC && sr;
    load     = sync_hit || ce;
    din      = sync_hit ? FORCE_VAL : d;
  end

  generate
    if (ST_MODE == ST_LATCH) begin : g_latch
      always_latch begin
        if (!rst_n)              q_r = '0;
        else if (IS_ASYNC && sr) q_r = FORCE_VAL;
        else if (clk && load)    q_r = din;
      end
    end else if (IS_ASYNC) begin : g_flop_async
      always_ff @(posedge clk or negedge rst_n or posedge sr) begin
        if (!rst_n)    q_r <= '0;
        else if (sr)   q_r <= FORCE_VAL;
        else if (load) q_r <= din;
      end
    end else begin : g_flop_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_r <= '0;
        else if (load) q_r <= din;
      end
    end
  endgenerate

  assign q = q_r;

  generate
    if (IS_ASYNC) begin : g_chk_async
      p_async_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && sr) |-> (q == FORCE_VAL));
    end
    if (!IS_ASYNC && ST_MODE == ST_FLOP) begin : g_chk_sync_flop
      p_sync_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && sr) |=> (q == FORCE_VAL));
      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !sr && !ce) |=> $stable(q));
      p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !sr && ce) |=> (q == $past(d)));
    end
  endgenerate

endmodule

// File: rtl/iocell_top.sv
module iocell_top
  import iocell_pkg::*;
#(
  parameter int       W        = 4,
  parameter sr_mode_e IN_SR    = SR_SYNC_CLR,
  parameter st_mode_e IN_ST    = ST_FLOP,
  parameter sr_mode_e OUT_SR   = SR_SYNC_CLR,
  parameter st_mode_e OUT_ST   = ST_FLOP,
  parameter sr_mode_e OE_SR    = SR_SYNC_CLR,
  parameter st_mode_e OE_ST    = ST_FLOP,
  parameter bit       INV_CLK  = 1'b0,
  parameter bit       INV_SR   = 1'b0,
  parameter bit       INV_ICE  = 1'b0,
  parameter bit       INV_OCE  = 1'b0,
  parameter bit       INV_TCE  = 1'b0,
  parameter bit       INV_IN   = 1'b0,
  parameter bit       INV_OUT  = 1'b0,
  parameter bit       INV_OE   = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sr,
  input  logic         in_ce,
  input  logic         out_ce,
  input  logic         oe_ce,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] core_out,
  input  logic [W-1:0] core_oe,
  output logic [W-1:0] in_q,
  output logic [W-1:0] in_direct,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);

  localparam logic [W-1:0] IN_MASK  = {W{INV_IN}};
  localparam logic [W-1:0] OUT_MASK = {W{INV_OUT}};
  localparam logic [W-1:0] OE_MASK  = {W{INV_OE}};

  logic         clk_eff;
  logic         sr_eff;
  logic         ice_eff;
  logic         oce_eff;
  logic         tce_eff;
  logic         rst_n_sync;
  logic [W-1:0] in_bits;
  logic [W-1:0] out_bank;
  logic [W-1:0] oe_bank;

  // polarity selection on every control and on both data paths
  assign clk_eff = clk    ^ INV_CLK;
  assign sr_eff  = sr     ^ INV_SR;
  assign ice_eff = in_ce  ^ INV_ICE;
  assign oce_eff = out_ce ^ INV_OCE;
  assign tce_eff = oe_ce  ^ INV_TCE;
  assign in_bits = pad_in ^ IN_MASK;

  iocell_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk_eff),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  iocell_store #(.W(W), .SR_MODE(IN_SR), .ST_MODE(IN_ST)) u_in_bank (
    .clk (clk_eff), .rst_n (rst_n_sync), .sr (sr_eff), .ce (ice_eff),
    .d   (in_bits), .q (in_q)
  );

  iocell_store #(.W(W), .SR_MODE(OUT_SR), .ST_MODE(OUT_ST)) u_out_bank (
    .clk (clk_eff), .rst_n (rst_n_sync), .sr (sr_eff), .ce (oce_eff),
    .d   (core_out), .q (out_bank)
  );

  iocell_store #(.W(W), .SR_MODE(OE_SR), .ST_MODE(OE_ST)) u_oe_bank (
    .clk (clk_eff), .rst_n (rst_n_sync), .sr (sr_eff), .ce (tce_eff),
    .d   (core_oe), .q (oe_bank)
  );

  assign in_direct = in_bits;
  assign pad_oe    = oe_bank ^ OE_MASK;
  assign pad_out   = pad_oe & (out_bank ^ OUT_MASK);

  p_reset_state_r1: assert property (@(posedge clk_eff)
    (!rst_n_sync) |-> (in_q == '0 && pad_oe == OE_MASK));

endmodule

// File: tb/sim_iocell_top.sv
module sim_iocell_top;
  import iocell_pkg::*;

  localparam int W = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic         sr, ice, oce, tce;
  logic [W-1:0] pad_in, core_out, core_oe;
  logic [W-1:0] in_q_a [4];
  logic [W-1:0] dir_a  [4];
  logic [W-1:0] pout_a [4];
  logic [W-1:0] poe_a  [4];

  logic         p_sr, p_ice, p_oce, p_tce;
  logic [W-1:0] p_pad_in, p_core_out, p_core_oe;
  logic [W-1:0] p_in_q, p_dir, p_pout, p_poe;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  logic [W-1:0] ei [4];
  logic [W-1:0] eo [4];
  logic [W-1:0] et [4];

  // instance k: capture bank mode k, drive bank mode k+1, enable bank mode k+2 (mod 4)
  for (genvar k = 0; k < 4; k++) begin : g_cfg
    iocell_top #(
      .W      (W),
      .IN_SR  (sr_mode_e'(k % 4)),       .IN_ST  (st_mode_e'(k % 2)),
      .OUT_SR (sr_mode_e'((k + 1) % 4)), .OUT_ST (st_mode_e'((k + 1) % 2)),
      .OE_SR  (sr_mode_e'((k + 2) % 4)), .OE_ST  (st_mode_e'(k / 2))
    ) u0 (
      .clk (clk), .rst_n (rst_n), .sr (sr),
      .in_ce (ice), .out_ce (oce), .oe_ce (tce),
      .pad_in (pad_in), .core_out (core_out), .core_oe (core_oe),
      .in_q (in_q_a[k]), .in_direct (dir_a[k]),
      .pad_out (pout_a[k]), .pad_oe (poe_a[k])
    );
  end

  iocell_top #(
    .W (W),
    .IN_SR (SR_SYNC_SET), .IN_ST (ST_FLOP),
    .OUT_SR (SR_ASYNC_CLR), .OUT_ST (ST_FLOP),
    .OE_SR (SR_SYNC_CLR), .OE_ST (ST_FLOP),
    .INV_CLK (1'b1), .INV_SR (1'b1), .INV_ICE (1'b1), .INV_OCE (1'b1),
    .INV_TCE (1'b1), .INV_IN (1'b1), .INV_OUT (1'b1), .INV_OE (1'b1)
  ) u_pol (
    .clk (clk), .rst_n (rst_n), .sr (p_sr),
    .in_ce (p_ice), .out_ce (p_oce), .oe_ce (p_tce),
    .pad_in (p_pad_in), .core_out (p_core_out), .core_oe (p_core_oe),
    .in_q (p_in_q), .in_direct (p_dir), .pad_out (p_pout), .pad_oe (p_poe)
  );

  function automatic int m_in(int k);   return k % 4;       endfunction
  function automatic int m_out(int k);  return (k + 1) % 4; endfunction
  function automatic int m_oe(int k);   return (k + 2) % 4; endfunction
  function automatic bit lat_in(int k); return (k % 2) == 1; endfunction
  function automatic bit lat_out(int k); return ((k + 1) % 2) == 1; endfunction
  function automatic bit lat_oe(int k); return (k / 2) == 1; endfunction
  function automatic bit is_async(int m); return m >= 2; endfunction
  function automatic logic [W-1:0] fval(int m);
    return (m == 0 || m == 2) ? {W{1'b1}} : {W{1'b0}};
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_grp(string tag);
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("%s u%0d in_q", tag, k), in_q_a[k], ei[k]);
      chk($sformatf("%s u%0d pad_oe", tag, k), poe_a[k], et[k]);
      chk($sformatf("%s u%0d pad_out", tag, k), pout_a[k], eo[k] & et[k]);
      chk($sformatf("R8 u%0d in_direct", k), dir_a[k], pad_in);
    end
  endtask

  task automatic load_all(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    @(negedge clk); #1;
    pad_in = a; core_out = b; core_oe = c;
    ice = 1'b1; oce = 1'b1; tce = 1'b1; sr = 1'b0;
    @(posedge clk); #2;
    for (int k = 0; k < 4; k++) begin
      ei[k] = a; eo[k] = b; et[k] = c;
    end
    chk_grp("R2 load");
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sr = 1'b0; ice = 1'b0; oce = 1'b0; tce = 1'b0;
    pad_in = 4'h5; core_out = 4'hA; core_oe = 4'hF;
    p_sr = 1'b1; p_ice = 1'b1; p_oce = 1'b1; p_tce = 1'b1;
    p_pad_in = 4'h0; p_core_out = 4'h0; p_core_oe = 4'hF;
    for (int k = 0; k < 4; k++) begin
      ei[k] = '0; eo[k] = '0; et[k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk_grp("R1 reset");
    chk("R1 pol in_q", p_in_q, 4'h0);
    chk("R1 pol pad_oe", p_poe, 4'hF);
    chk("R1 R9 pol pad_out", p_pout, 4'hF);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_flop_latch();
    @(negedge clk); #1;
    pad_in = 4'h3; core_out = 4'h6; core_oe = 4'hF;
    ice = 1'b1; oce = 1'b1; tce = 1'b1; sr = 1'b0;
    #1;
    chk_grp("R2 R3 closed while low");
    @(posedge clk); #2;
    for (int k = 0; k < 4; k++) begin
      ei[k] = 4'h3; eo[k] = 4'h6; et[k] = 4'hF;
    end
    chk_grp("R2 R3 after edge");
    #3;
    pad_in = 4'hC; core_out = 4'h9; core_oe = 4'h5;
    #2;
    for (int k = 0; k < 4; k++) begin
      if (lat_in(k))  ei[k] = 4'hC;
      if (lat_out(k)) eo[k] = 4'h9;
      if (lat_oe(k))  et[k] = 4'h5;
    end
    chk_grp("R3 transparent R2 flop steady");
    @(negedge clk); #1;
    pad_in = 4'h0; core_out = 4'h0; core_oe = 4'h0;
    #1;
    chk_grp("R3 latch holds low phase");
  endtask

  task automatic t_hold();
    load_all(4'h5, 4'hA, 4'hF);
    @(negedge clk); #1;
    ice = 1'b0; oce = 1'b0; tce = 1'b0;
    pad_in = 4'hE; core_out = 4'h1; core_oe = 4'h3;
    #1;
    chk_grp("R4 enable off low");
    @(posedge clk); #2;
    chk_grp("R4 enable off edge");
    pad_in = 4'h7; core_out = 4'h2; core_oe = 4'h0;
    #1;
    chk_grp("R4 enable off high");
  endtask

  task automatic t_sr(logic ce_val);
    load_all(4'h6, 4'h9, 4'hF);
    @(negedge clk); #1;
    pad_in = 4'hA; core_out = 4'h5; core_oe = 4'hF;
    ice = ce_val; oce = ce_val; tce = ce_val; sr = 1'b1;
    #1;
    for (int k = 0; k < 4; k++) begin
      if (is_async(m_in(k)))  ei[k] = fval(m_in(k));
      if (is_async(m_out(k))) eo[k] = fval(m_out(k));
      if (is_async(m_oe(k)))  et[k] = fval(m_oe(k));
    end
    chk_grp($sformatf("R5 R6 before edge ce=%0d", ce_val));
    @(posedge clk); #2;
    for (int k = 0; k < 4; k++) begin
      ei[k] = fval(m_in(k)); eo[k] = fval(m_out(k)); et[k] = fval(m_oe(k));
    end
    chk_grp($sformatf("R6 R7 at edge ce=%0d", ce_val));
    @(negedge clk); #1;
    sr = 1'b0; ice = 1'b0; oce = 1'b0; tce = 1'b0;
    #1;
    chk_grp("R7 held after release");
    @(posedge clk); #2;
    chk_grp("R7 held after release edge");
  endtask

  task automatic t_oe_mask();
    load_all(4'h9, 4'hF, 4'h6);
    load_all(4'h1, 4'h3, 4'h0);
    load_all(4'hF, 4'h5, 4'hF);
    chk("R9 u0 pad_out full", pout_a[0], 4'h5);
  endtask

  task automatic t_pol();
    @(posedge clk); #1;
    p_pad_in = 4'h3; p_core_out = 4'h6; p_core_oe = 4'h0;
    p_ice = 1'b0; p_oce = 1'b0; p_tce = 1'b0; p_sr = 1'b1;
    #1;
    chk("R10 pol no rising capture", p_in_q, 4'h0);
    chk("R8 pol in_direct", p_dir, 4'hC);
    @(negedge clk); #2;
    chk("R10 R8 pol falling capture", p_in_q, 4'hC);
    chk("R9 pol pad_oe", p_poe, 4'hF);
    chk("R9 R10 pol pad_out", p_pout, 4'h9);
    @(posedge clk); #1;
    p_sr = 1'b0;
    #1;
    chk("R5 R10 pol async clear", p_pout, 4'hF);
    chk("R6 R10 pol sync set waits", p_in_q, 4'hC);
    @(negedge clk); #2;
    chk("R6 R10 pol sync set", p_in_q, 4'hF);
    chk("R6 pol oe bank cleared", p_poe, 4'hF);
    @(posedge clk); #1;
    p_sr = 1'b1; p_ice = 1'b1; p_oce = 1'b1; p_tce = 1'b1;
    p_pad_in = 4'h0; p_core_out = 4'h0; p_core_oe = 4'hF;
    @(negedge clk); #2;
    chk("R4 R10 pol enable high ignored", p_in_q, 4'hF);
    chk("R4 R10 pol oe held", p_poe, 4'hF);
    chk("R4 R10 pol out held", p_pout, 4'hF);
  endtask

  initial begin
    t_reset();
    t_flop_latch();
    t_hold();
    t_sr(1'b1);
    t_sr(1'b0);
    t_oe_mask();
    t_pol();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule